// File: doc/BRIEF.md
# Windowed and Rotating Register Mapper

This block converts the logical register numbers used by an instruction into physical indices of a 128-entry integer register file. The lowest 32 logical numbers are global registers. They always map to themselves. Every higher logical number lies in the current procedure frame. That frame occupies a contiguous run of a circular 96-register pool, starting at a movable base. Each frame has a size and a local count. Its registers beyond the local count form the out area, and those hold the arguments passed to the next callee.

Commands arrive one per cycle on a small opcode input:

- A resize command sets the current frame's size, local count and rotating-region size.
- A call moves the base forward by the caller's local count, so the caller's out registers become the callee's first frame registers. It also pushes the caller's frame description onto an internal stack.
- A return pops that description off the stack.
- A loop pulse decrements the rotation base. The rotation base renames the registers of the rotating region, which starts at logical 32, for software-pipelined loops.

An illegal request is refused and flagged for one cycle. A request is illegal when it would overcommit the pool, overfill the stack, or return past the oldest frame. Moving frames to and from memory is handled elsewhere.

Top module: `regwin_mapper`

## Requirements
- R1: A lookup of a logical register below 32 returns that same number as the physical index.
- R2: For logical register r of 32 or more, let off = r − 32. If off is at or beyond the rotating size, the physical index is 32 + ((base + off) mod 96).
- R3: If off is below the rotating size rot, the physical index is 32 + ((base + ((off + rrb) mod rot)) mod 96), where rrb is the current rotation base.
- R4: Command LOOP (cmd_i = 4) decrements rrb by one, and from 0 it wraps to rot − 1. When rot is 0 it has no effect.
- R5: Command CALL (cmd_i = 2) sets base to (base + local count) mod 96. The callee's frame size, local count and rotating size come from the request inputs, and rrb becomes 0. A caller register 32 + local count + k therefore maps to the same physical index as callee register 32 + k.
- R6: Command RET (cmd_i = 3) restores the caller's base, frame size, local count, rotating size and rotation base exactly as they were before the matching CALL.
- R7: Command ALLOC (cmd_i = 1) resizes the current frame from the request inputs, keeps the base and clears rrb. If the registers held by suspended frames plus the requested size exceed 96, the command is refused: overflow_o pulses and the state is unchanged.
- R8: A CALL is refused in two cases. One is when the suspended frames' registers plus the caller's local count plus the requested size exceed 96. The other is when the stack already holds 8 frames. On refusal overflow_o is high for exactly the next cycle and no mapping changes.
- R9: A RET with an empty stack is refused: underflow_o is high for exactly the next cycle and no mapping changes.
- R10: preg_o is registered. It shows the translation of the lreg_i presented one cycle earlier, using the frame state before any command applied in that same cycle. Command 0 is a no-op.
- R11: After the synchronous reset the base, all frame sizes and rrb are 0 and the stack is empty. preg_o, overflow_o and underflow_o are all 0.

Requests must keep the local count and the rotating size no larger than the frame size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command: 0 none, 1 ALLOC, 2 CALL, 3 RET, 4 LOOP |
| req_size_i | input | 7 | Requested frame size for ALLOC or CALL |
| req_local_i | input | 7 | Requested local count for ALLOC or CALL |
| req_rot_i | input | 7 | Requested rotating-region size for ALLOC or CALL |
| lreg_i | input | 7 | Logical register number to translate |
| preg_o | output | 7 | Physical register index, one cycle later |
| overflow_o | output | 1 | One-cycle pulse: ALLOC or CALL refused |
| underflow_o | output | 1 | One-cycle pulse: RET refused on empty stack |

## Verification
The bench targets four corner cases:

- **Rotation wraparound.** It drives rrb across its wrap from 0 to rot − 1, and mixes lookups on both sides of the rotating-region edge. A design that wraps to the wrong value, or rotates registers outside the region, returns an index shifted by one or by rot.
- **Pool wraparound after nested calls.** It nests calls until the base wraps past the top of the pool. A missing modulo then yields indices outside the pool or inside the global range.
- **Refusal limits.** It tests the ninth nested call, pool overcommit by both ALLOC and CALL, and a return on an empty stack. A design that partly applies a refused command loses the caller frame, so later returns restore the wrong base.
- **Same-cycle lookup.** It checks a lookup issued in the same cycle as a CALL. A design that forwards the new state there translates with the callee's base.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int unsigned PHYS_REGS  = 128;
  localparam int unsigned FIXED_REGS = 32;
  localparam int unsigned IDX_W      = $clog2(PHYS_REGS);

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ALLOC = 3'd1,
    CMD_CALL  = 3'd2,
    CMD_RET   = 3'd3,
    CMD_LOOP  = 3'd4
  } win_cmd_e;

  typedef struct packed {
    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] size;
    logic [IDX_W-1:0] locl;
    logic [IDX_W-1:0] rot;
    logic [IDX_W-1:0] rrb;
  } frame_t;

endpackage

// File: rtl/regwin_stack.sv
module regwin_stack #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned ENTRY_W = 35
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic               pop,
  input  logic [ENTRY_W-1:0] wdata,
  output logic [ENTRY_W-1:0] rdata,
  output logic               empty,
  output logic               full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned SP_W  = $clog2(DEPTH + 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [SP_W-1:0]    sp;
  logic [SP_W-1:0]    sp_dec;

  assign sp_dec = sp - 1'b1;
  assign empty  = (sp == '0);
  assign full   = (sp == SP_W'(DEPTH));
  assign rdata  = empty ? '0 : mem[PTR_W'(sp_dec)];

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[PTR_W'(sp)] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) sp <= '0;
    else if (push && !full) sp <= sp + 1'b1;
    else if (pop && !empty) sp <= sp_dec;
  end

  // R8: the controller never pushes onto a full stack
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (rst) full |-> !push);
  // R9: the controller never pops an empty stack
  a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (rst) empty |-> !pop);

endmodule

// File: rtl/regwin_ctl.sv
module regwin_ctl
  import regwin_pkg::*;
#(
  parameter int unsigned POOL = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmd,
  input  logic [IDX_W-1:0] req_size,
  input  logic [IDX_W-1:0] req_local,
  input  logic [IDX_W-1:0] req_rot,
  input  frame_t           stk_top,
  input  logic             stk_empty,
  input  logic             stk_full,
  output logic             stk_push,
  output logic             stk_pop,
  output frame_t           cur,
  output logic             overflow,
  output logic             underflow
);
  localparam int unsigned SUM_W = IDX_W + 2;

  logic [IDX_W-1:0] held;       // registers owned by suspended frames
  logic [SUM_W-1:0] call_need;
  logic [SUM_W-1:0] alloc_need;
  logic [IDX_W:0]   base_sum;
  logic             call_bad, alloc_bad;
  logic             is_alloc, is_call, is_ret, is_loop;

  assign is_alloc = (cmd == CMD_ALLOC);
  assign is_call  = (cmd == CMD_CALL);
  assign is_ret   = (cmd == CMD_RET);
  assign is_loop  = (cmd == CMD_LOOP);

  assign call_need  = SUM_W'(held) + SUM_W'(cur.locl) + SUM_W'(req_size);
  assign alloc_need = SUM_W'(held) + SUM_W'(req_size);
  assign call_bad   = stk_full || (call_need > SUM_W'(POOL));
  assign alloc_bad  = alloc_need > SUM_W'(POOL);
  assign base_sum   = (IDX_W+1)'(cur.base) + (IDX_W+1)'(cur.locl);

  assign stk_push = is_call && !call_bad;
  assign stk_pop  = is_ret && !stk_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= '0;
      held      <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= (is_alloc && alloc_bad) || (is_call && call_bad);
      underflow <= is_ret && stk_empty;
      if (is_alloc && !alloc_bad) begin
        cur.size <= req_size;
        cur.locl <= req_local;
        cur.rot  <= req_rot;
        cur.rrb  <= '0;
      end else if (stk_push) begin
        cur.base <= (base_sum >= (IDX_W+1)'(POOL)) ? IDX_W'(base_sum - (IDX_W+1)'(POOL))
                                                   : IDX_W'(base_sum);
        cur.size <= req_size;
        cur.locl <= req_local;
        cur.rot  <= req_rot;
        cur.rrb  <= '0;
        held     <= held + cur.locl;
      end else if (stk_pop) begin
        cur  <= stk_top;
        held <= held - stk_top.locl;
      end else if (is_loop && cur.rot != '0) begin
        cur.rrb <= (cur.rrb == '0) ? cur.rot - 1'b1 : cur.rrb - 1'b1;
      end
    end
  end

  // R4: rotation base stays inside the rotating region
  a_r4_rrb_in_range: assert property (@(posedge clk) disable iff (rst)
    (cur.rot != '0) |-> (cur.rrb < cur.rot));
  // R7: committed registers never exceed the pool
  a_r7_pool_bound: assert property (@(posedge clk) disable iff (rst)
    ((IDX_W+1)'(held) + (IDX_W+1)'(cur.size)) <= (IDX_W+1)'(POOL));
  // R8: a refused command leaves the frame untouched
  a_r8_ovf_keeps_frame: assert property (@(posedge clk) disable iff (rst)
    overflow |-> $stable(cur));
  // R9: a refused return leaves the frame untouched
  a_r9_unf_keeps_frame: assert property (@(posedge clk) disable iff (rst)
    underflow |-> ($stable(cur) && stk_empty));

endmodule

// File: rtl/regwin_xlate.sv
module regwin_xlate
  import regwin_pkg::*;
#(
  parameter int unsigned FIXED = 32,
  parameter int unsigned POOL  = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lreg,
  input  logic [IDX_W-1:0] base,
  input  logic [IDX_W-1:0] rot,
  input  logic [IDX_W-1:0] rrb,
  output logic [IDX_W-1:0] preg
);
  logic [IDX_W-1:0] off, eff;
  logic [IDX_W:0]   rsum, psum;
  logic [IDX_W-1:0] roff, wrapped;
  logic             is_fixed;

  assign is_fixed = (lreg < IDX_W'(FIXED));
  assign off      = lreg - IDX_W'(FIXED);
  assign rsum     = (IDX_W+1)'(off) + (IDX_W+1)'(rrb);
  assign roff     = (rsum >= (IDX_W+1)'(rot)) ? IDX_W'(rsum - (IDX_W+1)'(rot)) : IDX_W'(rsum);
  assign eff      = (off < rot) ? roff : off;
  assign psum     = (IDX_W+1)'(base) + (IDX_W+1)'(eff);
  assign wrapped  = (psum >= (IDX_W+1)'(POOL)) ? IDX_W'(psum - (IDX_W+1)'(POOL)) : IDX_W'(psum);

  always_ff @(posedge clk) begin
    if (rst) preg <= '0;
    else     preg <= is_fixed ? lreg : IDX_W'(FIXED) + wrapped;
  end

  // R1: global registers pass straight through one cycle later
  a_r1_fixed_identity: assert property (@(posedge clk) disable iff (rst)
    (lreg < IDX_W'(FIXED)) |=> (preg == $past(lreg)));
  // R2: frame registers never land in the global range
  a_r2_in_pool: assert property (@(posedge clk) disable iff (rst)
    (lreg >= IDX_W'(FIXED)) |=> (preg >= IDX_W'(FIXED)));

endmodule

// File: rtl/regwin_mapper.sv
module regwin_mapper
  import regwin_pkg::*;
#(
  parameter int unsigned STACK_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmd_i,
  input  logic [IDX_W-1:0] req_size_i,
  input  logic [IDX_W-1:0] req_local_i,
  input  logic [IDX_W-1:0] req_rot_i,
  input  logic [IDX_W-1:0] lreg_i,
  output logic [IDX_W-1:0] preg_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  localparam int unsigned POOL    = PHYS_REGS - FIXED_REGS;
  localparam int unsigned ENTRY_W = $bits(frame_t);

  frame_t             cur;
  logic [ENTRY_W-1:0] stk_rdata;
  logic               stk_push, stk_pop, stk_empty, stk_full;

  regwin_stack #(.DEPTH(STACK_DEPTH), .ENTRY_W(ENTRY_W)) u_stack (
    .clk(clk), .rst(rst), .push(stk_push), .pop(stk_pop),
    .wdata(cur), .rdata(stk_rdata), .empty(stk_empty), .full(stk_full)
  );

  regwin_ctl #(.POOL(POOL)) u_ctl (
    .clk(clk), .rst(rst), .cmd(cmd_i),
    .req_size(req_size_i), .req_local(req_local_i), .req_rot(req_rot_i),
    .stk_top(frame_t'(stk_rdata)), .stk_empty(stk_empty), .stk_full(stk_full),
    .stk_push(stk_push), .stk_pop(stk_pop), .cur(cur),
    .overflow(overflow_o), .underflow(underflow_o)
  );

  regwin_xlate #(.FIXED(FIXED_REGS), .POOL(POOL)) u_xlate (
    .clk(clk), .rst(rst), .lreg(lreg_i),
    .base(cur.base), .rot(cur.rot), .rrb(cur.rrb), .preg(preg_o)
  );

endmodule

// File: tb/test_regwin_mapper.sv
`timescale 1ns/1ps
module test_regwin_mapper;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd_i = 3'd0;
  logic [6:0] req_size_i = '0, req_local_i = '0, req_rot_i = '0, lreg_i = '0;
  logic [6:0] preg_o;
  logic       overflow_o, underflow_o;

  always #4 clk = ~clk;

  regwin_mapper i_regwin_mapper (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .req_size_i(req_size_i),
    .req_local_i(req_local_i), .req_rot_i(req_rot_i), .lreg_i(lreg_i),
    .preg_o(preg_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // reference frame model
  int m_base, m_size, m_loc, m_rot, m_rrb, m_held, m_sp;
  int s_base[8], s_size[8], s_loc[8], s_rot[8], s_rrb[8];
  int exp_preg, exp_ovf, exp_unf;
  string exp_tag;

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int ref_map(int r);
    int off, eff;
    if (r < 32) return r;
    off = r - 32;
    eff = (off < m_rot) ? (off + m_rrb) % m_rot : off;
    return 32 + (m_base + eff) % 96;
  endfunction

  function automatic string ref_tag(int r);
    if (r < 32) return "R1";
    if (r - 32 < m_rot) return "R3";
    return "R2";
  endfunction

  task automatic model_reset();
    m_base = 0; m_size = 0; m_loc = 0; m_rot = 0; m_rrb = 0; m_held = 0; m_sp = 0;
  endtask

  task automatic model_apply(int c, int sz, int lc, int rt);
    exp_ovf = 0; exp_unf = 0;
    case (c)
      1: if (m_held + sz > 96) exp_ovf = 1;
         else begin m_size = sz; m_loc = lc; m_rot = rt; m_rrb = 0; end
      2: if (m_sp == 8 || m_held + m_loc + sz > 96) exp_ovf = 1;
         else begin
           s_base[m_sp] = m_base; s_size[m_sp] = m_size; s_loc[m_sp] = m_loc;
           s_rot[m_sp] = m_rot; s_rrb[m_sp] = m_rrb; m_sp++;
           m_held += m_loc; m_base = (m_base + m_loc) % 96;
           m_size = sz; m_loc = lc; m_rot = rt; m_rrb = 0;
         end
      3: if (m_sp == 0) exp_unf = 1;
         else begin
           m_sp--; m_base = s_base[m_sp]; m_size = s_size[m_sp]; m_loc = s_loc[m_sp];
           m_rot = s_rot[m_sp]; m_rrb = s_rrb[m_sp]; m_held -= m_loc;
         end
      4: if (m_rot != 0) m_rrb = (m_rrb == 0) ? m_rot - 1 : m_rrb - 1;
      default: ;
    endcase
  endtask

  // one cycle: command plus lookup, checked against the model (R10 timing)
  task automatic step(int c, int sz, int lc, int rt, int r);
    @(negedge clk);
    cmd_i = 3'(c); req_size_i = 7'(sz); req_local_i = 7'(lc); req_rot_i = 7'(rt); lreg_i = 7'(r);
    exp_preg = ref_map(r);
    exp_tag  = ref_tag(r);
    model_apply(c, sz, lc, rt);
    @(posedge clk); #1;
    check(exp_tag, int'(preg_o), exp_preg);
    check(c == 3 ? "R9 underflow" : "R8 overflow", c == 3 ? int'(underflow_o) : int'(overflow_o),
          c == 3 ? exp_unf : exp_ovf);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    int p;
    seed_dummy = $urandom(32'd20240611);
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R11 preg after reset", int'(preg_o), 0);
    check("R11 overflow after reset", int'(overflow_o), 0);
    check("R11 underflow after reset", int'(underflow_o), 0);
    @(negedge clk); rst = 1'b0;

    // R11/R9: empty stack, zero-size frame
    step(3, 0, 0, 0, 40);
    check("R9 underflow pulse", int'(underflow_o), 1);
    check("R11 base zero maps 40", int'(preg_o), 40);
    step(0, 0, 0, 0, 5);
    check("R9 underflow one cycle", int'(underflow_o), 0);
    check("R1 identity 5", int'(preg_o), 5);

    // R7/R4: frame with rotating region of 8
    step(1, 20, 12, 8, 0);
    step(4, 0, 0, 0, 32);
    check("R4 rrb 0 at lookup", int'(preg_o), 32);
    step(4, 0, 0, 0, 32);
    check("R4 wrap to rot-1", int'(preg_o), 39);
    step(4, 0, 0, 0, 32);
    step(0, 0, 0, 0, 32);
    check("R4 after three decrements", int'(preg_o), 37);
    step(0, 0, 0, 0, 45);
    check("R2 outside rotating region", int'(preg_o), 45);

    // R10: lookup in same cycle as CALL uses caller frame
    step(2, 16, 10, 0, 32);
    check("R10 same-cycle lookup uses old base", int'(preg_o), 37);
    step(0, 0, 0, 0, 32);
    check("R5 callee input overlaps caller out", int'(preg_o), 44);
    step(0, 0, 0, 0, 47);
    check("R5 callee 47 at base 12", int'(preg_o), 59);
    step(3, 0, 0, 0, 0);
    step(0, 0, 0, 0, 32);
    check("R6 rotation restored", int'(preg_o), 37);
    step(0, 0, 0, 0, 44);
    check("R6 base restored", int'(preg_o), 44);

    // R7: alloc overcommit refused
    step(1, 100, 0, 0, 33);
    check("R7 alloc overflow", int'(overflow_o), 1);
    step(0, 0, 0, 0, 32);
    check("R7 frame unchanged", int'(preg_o), 37);

    // R8: ninth nested call refused
    step(1, 4, 2, 0, 0);
    for (int i = 0; i < 8; i++) step(2, 4, 2, 0, 33);
    check("R5 base after 8 calls", int'(preg_o), 32 + 14 + 1);
    step(2, 4, 2, 0, 32);
    check("R8 stack full overflow", int'(overflow_o), 1);
    step(0, 0, 0, 0, 32);
    check("R8 base kept", int'(preg_o), 48);
    for (int i = 0; i < 8; i++) step(3, 0, 0, 0, 32);
    step(3, 0, 0, 0, 32);
    check("R9 underflow after unwind", int'(underflow_o), 1);

    // R8: pool overcommit on call, with base wrap
    step(1, 90, 90, 0, 0);
    step(2, 7, 0, 0, 0);
    check("R8 pool overflow on call", int'(overflow_o), 1);
    step(2, 6, 3, 0, 0);
    step(0, 0, 0, 0, 40);
    check("R2 pool wraparound", int'(preg_o), 32 + (90 + 8) % 96);
    step(3, 0, 0, 0, 0);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int c, sz, lc, rt, r;
      p  = $urandom_range(99);
      c  = (p < 25) ? 4 : (p < 45) ? 2 : (p < 65) ? 3 : (p < 80) ? 1 : 0;
      sz = $urandom_range(40);
      lc = $urandom_range(sz);
      rt = $urandom_range(sz);
      r  = $urandom_range(127);
      step(c, sz, lc, rt, r);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule